// File: doc/BRIEF.md
# Dual-Clock Single-Bit FIFO with Programmable Threshold Flags

This block is a serial first-in first-out buffer that holds 256 single-bit entries. A producer clocks bits in on its own write clock, and a consumer takes them out on a separate read clock. The two clocks may be one shared clock or two unrelated clocks. A write needs two qualifiers of opposite polarity, both active. A read needs an active-low read enable. The read data comes from a holding register. An active-low output enable either drives that register onto the data pin or releases the pin to high impedance.

Four active-low status outputs report the fill level. Empty and almost-empty are produced in the read-clock domain. Full and almost-full are produced in the write-clock domain. The pointers cross between domains as Gray codes through a chain of synchronizer flops, so a flag seen from the far side can lag by the synchronizer delay, but never in the direction that would allow an overrun or an underrun. The two threshold offsets are loaded on the write clock through an 8-bit program port under a load strobe. The loads alternate between the two offsets, and a load cycle blocks any data write in that cycle.

An asynchronous active-low reset clears both pointers, sets empty and almost-empty, clears full and almost-full, and puts both offsets back to 7.

Top module: `bitq_fifo_dc`

## Requirements
- R1: A bit on `din` is stored at a rising `wr_clk` edge only when `wr_en_n` is 0 and `wr_en_p` is 1. Any other combination stores nothing.
- R2: At a rising `rd_clk` edge with `rd_en_n` at 0 and the FIFO not empty, the oldest stored bit appears on `dout` after that edge. Bits leave in the order they were written, including when a write and a read happen at the same edge.
- R3: `empty_n` is 0 while no bit is stored. It goes to 0 at the edge of the read that removes the last bit, and it goes to 1 within four read-clock edges after a write into an empty FIFO.
- R4: `full_n` goes to 0 at the write edge that stores the 256th bit, and it stays 0 while 256 bits are held.
- R5: A write attempted while `full_n` is 0 changes neither the stored bits nor the write pointer. Draining afterwards yields exactly the 256 bits written before.
- R6: A read attempted while `empty_n` is 0 leaves `dout` and the read pointer unchanged. With `rd_en_n` at 1, `dout` also holds its last value.
- R7: `aempty_n` is 0 when the fill level is less than or equal to the empty offset, and 1 otherwise.
- R8: `afull_n` is 0 when the fill level is greater than or equal to 256 minus the full offset, and 1 otherwise. Full always implies almost-full.
- R9: When `prog_load` is 1 at a rising `wr_clk` edge, `prog_val` is captured into an offset register. The first load after reset goes to the empty offset, the next load goes to the full offset, and later loads keep alternating. No data bit is written in a load cycle, whatever the write enables are.
- R10: When `out_en_n` is 1, `dout` is high impedance. When it is 0, `dout` shows the read register.
- R11: Reset (`rst_n` at 0) clears both pointers and the read register to 0. It forces `empty_n` and `aempty_n` to 0 and `full_n` and `afull_n` to 1, and it restores both offsets to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, may equal or be unrelated to `wr_clk` |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| din | input | 1 | Serial data bit to store |
| wr_en_n | input | 1 | Active-low write qualifier |
| wr_en_p | input | 1 | Active-high write qualifier |
| prog_load | input | 1 | Offset load strobe, sampled on `wr_clk` |
| prog_val | input | 8 | Offset value to load |
| rd_en_n | input | 1 | Active-low read enable |
| out_en_n | input | 1 | Active-low output enable for `dout` |
| dout | output | 1 | Read data, high impedance when disabled |
| empty_n | output | 1 | Active-low empty flag (read domain) |
| aempty_n | output | 1 | Active-low almost-empty flag (read domain) |
| afull_n | output | 1 | Active-low almost-full flag (write domain) |
| full_n | output | 1 | Active-low full flag (write domain) |

## Verification
The offset load strobe and a qualified data write can fall on the same write-clock edge. The bench holds both write qualifiers active with `din` at 1 while it pulses `prog_load`. It then waits out the synchronizer delay and requires `empty_n` to stay low, and it requires the loaded value to show up in the almost-empty threshold. A read and a write can also share an edge: with six bits queued, the bench does eight cycles of concurrent push and pop and compares every popped bit against its own queue model.

// File: rtl/bitq_pkg.sv
package bitq_pkg;

   typedef enum logic {
      OFS_TGT_EMPTY = 1'b0,
      OFS_TGT_FULL  = 1'b1
   } ofs_tgt_e;

   function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] r;
      r[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         r[i] = r[i+1] ^ g[i];
      end
      return r;
   endfunction

endpackage

// File: rtl/bitq_sync.sv
module bitq_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bitq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) begin
            chain[i] <= '0;
         end
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/bitq_store.sv
module bitq_store #(
   parameter  int DEPTH = 256,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wbit,
   input  logic [AW-1:0] raddr,
   output logic          rbit
);

   logic [DEPTH-1:0] cells;

   always_ff @(posedge wr_clk) begin
      if (we) begin
         cells[waddr] <= wbit;
      end
   end

   assign rbit = cells[raddr];

endmodule

// File: rtl/bitq_wr_ctl.sv
module bitq_wr_ctl
   import bitq_pkg::*;
#(
   parameter  int DEPTH   = 256,
   parameter  int OW      = 8,
   parameter  int DEF_OFS = 7,
   localparam int AW      = $clog2(DEPTH),
   localparam int PW      = AW + 1
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic          ld_req,
   input  logic [OW-1:0] ld_val,
   input  logic [PW-1:0] rgray_s,
   output logic          wr_fire,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wgray,
   output logic [PW-1:0] wbin,
   output logic          full_n,
   output logic          afull_n,
   output logic [OW-1:0] e_ofs
);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("bitq_wr_ctl: DEPTH must be a power of two");
      end
      if (OW > AW) begin : g_bad_ow
         $error("bitq_wr_ctl: offset width must not exceed address width");
      end
      if (DEF_OFS >= DEPTH) begin : g_bad_def
         $error("bitq_wr_ctl: default offset must be below DEPTH");
      end
   endgenerate

   ofs_tgt_e      tgt;
   logic [OW-1:0] f_ofs;
   logic [PW-1:0] wbin_nx;
   logic [PW-1:0] rbin_s;
   logic [PW-1:0] lvl_nx;
   logic [PW-1:0] af_thr;

   assign wr_fire = wr_req & ~ld_req & full_n;
   assign wbin_nx = wbin + PW'(wr_fire);
   assign rbin_s  = PW'(gray_to_bin(32'(rgray_s)));
   assign lvl_nx  = wbin_nx - rbin_s;
   assign af_thr  = PW'(DEPTH) - PW'(f_ofs);
   assign waddr   = wbin[AW-1:0];

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin    <= '0;
         wgray   <= '0;
         full_n  <= 1'b1;
         afull_n <= 1'b1;
      end else begin
         wbin    <= wbin_nx;
         wgray   <= PW'(bin_to_gray(32'(wbin_nx)));
         full_n  <= (lvl_nx != PW'(DEPTH));
         afull_n <= (lvl_nx < af_thr);
      end
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         e_ofs <= OW'(DEF_OFS);
         f_ofs <= OW'(DEF_OFS);
         tgt   <= OFS_TGT_EMPTY;
      end else if (ld_req) begin
         if (tgt == OFS_TGT_EMPTY) begin
            e_ofs <= ld_val;
            tgt   <= OFS_TGT_FULL;
         end else begin
            f_ofs <= ld_val;
            tgt   <= OFS_TGT_EMPTY;
         end
      end
   end

endmodule

// File: rtl/bitq_rd_ctl.sv
module bitq_rd_ctl
   import bitq_pkg::*;
#(
   parameter  int DEPTH = 256,
   parameter  int OW    = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic [PW-1:0] wgray_s,
   input  logic [OW-1:0] e_ofs,
   input  logic          rbit,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic [PW-1:0] rbin,
   output logic          q,
   output logic          empty_n,
   output logic          aempty_n
);

   logic          rd_fire;
   logic [PW-1:0] rbin_nx;
   logic [PW-1:0] wbin_s;
   logic [PW-1:0] lvl_nx;

   assign rd_fire = rd_req & empty_n;
   assign rbin_nx = rbin + PW'(rd_fire);
   assign wbin_s  = PW'(gray_to_bin(32'(wgray_s)));
   assign lvl_nx  = wbin_s - rbin_nx;
   assign raddr   = rbin[AW-1:0];

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         q        <= 1'b0;
         empty_n  <= 1'b0;
         aempty_n <= 1'b0;
      end else begin
         rbin     <= rbin_nx;
         rgray    <= PW'(bin_to_gray(32'(rbin_nx)));
         empty_n  <= (lvl_nx != '0);
         aempty_n <= (lvl_nx > PW'(e_ofs));
         if (rd_fire) begin
            q <= rbit;
         end
      end
   end

endmodule

// File: rtl/bitq_fifo_dc.sv
module bitq_fifo_dc
   import bitq_pkg::*;
#(
   parameter  int DEPTH       = 256,
   parameter  int OW          = 8,
   parameter  int DEF_OFS     = 7,
   parameter  int SYNC_STAGES = 2,
   parameter  bit SYNC_BYPASS = 1'b0,
   localparam int AW          = $clog2(DEPTH),
   localparam int PW          = AW + 1
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          din,
   input  logic          wr_en_n,
   input  logic          wr_en_p,
   input  logic          prog_load,
   input  logic [OW-1:0] prog_val,
   input  logic          rd_en_n,
   input  logic          out_en_n,
   output logic          dout,
   output logic          empty_n,
   output logic          aempty_n,
   output logic          afull_n,
   output logic          full_n
);

   logic          wr_fire;
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;
   logic [PW-1:0] wgray;
   logic [PW-1:0] rgray;
   logic [PW-1:0] wgray_rd;
   logic [PW-1:0] rgray_wr;
   logic [PW-1:0] w_bin;
   logic [PW-1:0] r_bin;
   logic [OW-1:0] e_ofs;
   logic          rbit;
   logic          q_reg;

   bitq_wr_ctl #(
      .DEPTH   (DEPTH),
      .OW      (OW),
      .DEF_OFS (DEF_OFS)
   ) u_wr (
      .wr_clk  (wr_clk),
      .rst_n   (rst_n),
      .wr_req  (~wr_en_n & wr_en_p),
      .ld_req  (prog_load),
      .ld_val  (prog_val),
      .rgray_s (rgray_wr),
      .wr_fire (wr_fire),
      .waddr   (waddr),
      .wgray   (wgray),
      .wbin    (w_bin),
      .full_n  (full_n),
      .afull_n (afull_n),
      .e_ofs   (e_ofs)
   );

   bitq_rd_ctl #(
      .DEPTH (DEPTH),
      .OW    (OW)
   ) u_rd (
      .rd_clk   (rd_clk),
      .rst_n    (rst_n),
      .rd_req   (~rd_en_n),
      .wgray_s  (wgray_rd),
      .e_ofs    (e_ofs),
      .rbit     (rbit),
      .raddr    (raddr),
      .rgray    (rgray),
      .rbin     (r_bin),
      .q        (q_reg),
      .empty_n  (empty_n),
      .aempty_n (aempty_n)
   );

   bitq_store #(
      .DEPTH (DEPTH)
   ) u_mem (
      .wr_clk (wr_clk),
      .we     (wr_fire),
      .waddr  (waddr),
      .wbit   (din),
      .raddr  (raddr),
      .rbit   (rbit)
   );

   generate
      if (SYNC_BYPASS) begin : g_direct
         assign wgray_rd = wgray;
         assign rgray_wr = rgray;
      end else begin : g_sync
         bitq_sync #(
            .W      (PW),
            .STAGES (SYNC_STAGES)
         ) u_w2r (
            .clk   (rd_clk),
            .rst_n (rst_n),
            .d     (wgray),
            .q     (wgray_rd)
         );
         bitq_sync #(
            .W      (PW),
            .STAGES (SYNC_STAGES)
         ) u_r2w (
            .clk   (wr_clk),
            .rst_n (rst_n),
            .d     (rgray),
            .q     (rgray_wr)
         );
      end
   endgenerate

   assign dout = out_en_n ? 1'bz : q_reg;

endmodule

// File: rtl/bitq_fifo_chk.sv
module bitq_fifo_chk #(
   parameter int PW = 9
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          wr_en_n,
   input logic          wr_en_p,
   input logic          prog_load,
   input logic          rd_en_n,
   input logic          full_n,
   input logic          afull_n,
   input logic          empty_n,
   input logic          aempty_n,
   input logic [PW-1:0] w_bin,
   input logic [PW-1:0] r_bin,
   input logic          q_reg
);

   assert_wr_gate_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en_n || !wr_en_p) |=> $stable(w_bin));

   assert_full_block_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!full_n && !wr_en_n && wr_en_p) |=> $stable(w_bin));

   assert_empty_block_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n && !rd_en_n) |=> ($stable(r_bin) && $stable(q_reg)));

   assert_q_hold_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_en_n |=> $stable(q_reg));

   assert_ae_cover_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);

   assert_af_cover_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> !afull_n);

   assert_load_inhibit_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
      prog_load |=> $stable(w_bin));

   assert_rst_wflags_R11: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (full_n && afull_n));

   assert_rst_rflags_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!empty_n && !aempty_n));

endmodule

bind bitq_fifo_dc bitq_fifo_chk #(.PW(PW)) u_chk (
   .wr_clk    (wr_clk),
   .rd_clk    (rd_clk),
   .rst_n     (rst_n),
   .wr_en_n   (wr_en_n),
   .wr_en_p   (wr_en_p),
   .prog_load (prog_load),
   .rd_en_n   (rd_en_n),
   .full_n    (full_n),
   .afull_n   (afull_n),
   .empty_n   (empty_n),
   .aempty_n  (aempty_n),
   .w_bin     (w_bin),
   .r_bin     (r_bin),
   .q_reg     (q_reg)
);

// File: tb/bitq_fifo_dc_tb_top.sv
module bitq_fifo_dc_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       din = 1'b0;
   logic       wr_en_n = 1'b1;
   logic       wr_en_p = 1'b0;
   logic       prog_load = 1'b0;
   logic [7:0] prog_val = 8'd0;
   logic       rd_en_n = 1'b1;
   logic       out_en_n = 1'b0;
   wire        dout;
   wire        empty_n;
   wire        aempty_n;
   wire        afull_n;
   wire        full_n;

   pullup (dout);

   always #10 clk = ~clk;

   bitq_fifo_dc dut_i (
      .wr_clk    (clk),
      .rd_clk    (clk),
      .rst_n     (rst_n),
      .din       (din),
      .wr_en_n   (wr_en_n),
      .wr_en_p   (wr_en_p),
      .prog_load (prog_load),
      .prog_val  (prog_val),
      .rd_en_n   (rd_en_n),
      .out_en_n  (out_en_n),
      .dout      (dout),
      .empty_n   (empty_n),
      .aempty_n  (aempty_n),
      .afull_n   (afull_n),
      .full_n    (full_n)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit mq[$];

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input bit b);
      din = b; wr_en_n = 1'b0; wr_en_p = 1'b1;
      @(negedge clk);
      wr_en_n = 1'b1; wr_en_p = 1'b0;
      mq.push_back(b);
   endtask

   task automatic pop(input string tag);
      bit e;
      e = mq.pop_front();
      rd_en_n = 1'b0;
      @(negedge clk);
      rd_en_n = 1'b1;
      chk(tag, dout, e);
   endtask

   task automatic drain(input string tag);
      while (mq.size() > 0) pop(tag);
   endtask

   task automatic do_load(input logic [7:0] v);
      prog_val = v; prog_load = 1'b1;
      @(negedge clk);
      prog_load = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      settle(2);
      rst_n = 1'b1;
      settle(1);
      mq.delete();
   endtask

   task automatic t_reset();
      chk("R11 empty_n after reset", empty_n, 1'b0);
      chk("R11 aempty_n after reset", aempty_n, 1'b0);
      chk("R11 full_n after reset", full_n, 1'b1);
      chk("R11 afull_n after reset", afull_n, 1'b1);
      chk("R11 dout after reset", dout, 1'b0);
   endtask

   task automatic t_order();
      push(1); push(0); push(1); push(1); push(0); push(0); push(1);
      settle(4);
      chk("R3 empty_n with data", empty_n, 1'b1);
      drain("R2 read order");
      chk("R3 empty_n at last read", empty_n, 1'b0);
   endtask

   task automatic t_gate();
      din = 1'b1; wr_en_n = 1'b1; wr_en_p = 1'b1;
      @(negedge clk);
      wr_en_n = 1'b0; wr_en_p = 1'b0;
      @(negedge clk);
      wr_en_n = 1'b1;
      settle(4);
      chk("R1 no write with one qualifier", empty_n, 1'b0);
      push(0);
      settle(4);
      chk("R1 qualified write stored", empty_n, 1'b1);
      pop("R1 qualified write data");
   endtask

   task automatic t_empty_read();
      rd_en_n = 1'b0;
      @(negedge clk);
      rd_en_n = 1'b1;
      chk("R6 dout after read on empty", dout, 1'b0);
      push(1);
      settle(4);
      pop("R6 pointer kept on empty read");
      push(0);
      settle(4);
      chk("R6 dout held without read", dout, 1'b1);
      drain("R6 data after hold");
   endtask

   task automatic t_simul();
      for (int i = 0; i < 6; i++) push(i[0]);
      settle(4);
      for (int i = 0; i < 8; i++) begin
         bit nb;
         bit e;
         nb = (i % 3) == 1;
         e = mq.pop_front();
         mq.push_back(nb);
         din = nb; wr_en_n = 1'b0; wr_en_p = 1'b1; rd_en_n = 1'b0;
         @(negedge clk);
         wr_en_n = 1'b1; wr_en_p = 1'b0; rd_en_n = 1'b1;
         chk("R2 concurrent read and write", dout, e);
      end
      settle(4);
      drain("R2 drain after concurrent");
   endtask

   task automatic t_aempty();
      for (int i = 0; i < 7; i++) push(i[1]);
      settle(4);
      chk("R7 aempty_n at level 7", aempty_n, 1'b0);
      push(1);
      settle(4);
      chk("R7 aempty_n at level 8", aempty_n, 1'b1);
      drain("R7 drain");
      chk("R7 aempty_n when drained", aempty_n, 1'b0);
   endtask

   task automatic t_full();
      for (int i = 0; i < 248; i++) push((i % 3) == 0);
      settle(4);
      chk("R8 afull_n at level 248", afull_n, 1'b1);
      push(1);
      chk("R8 afull_n at level 249", afull_n, 1'b0);
      for (int i = 0; i < 6; i++) push(i[0]);
      chk("R4 full_n at level 255", full_n, 1'b1);
      push(0);
      chk("R4 full_n at level 256", full_n, 1'b0);
      din = 1'b1; wr_en_n = 1'b0; wr_en_p = 1'b1;
      settle(2);
      wr_en_n = 1'b1; wr_en_p = 1'b0;
      settle(4);
      chk("R5 full_n after write on full", full_n, 1'b0);
      drain("R5 contents after write on full");
      chk("R5 empty_n after 256 reads", empty_n, 1'b0);
      settle(4);
      chk("R5 no extra bit stored", empty_n, 1'b0);
   endtask

   task automatic t_program();
      din = 1'b1; wr_en_n = 1'b0; wr_en_p = 1'b1;
      do_load(8'd3);
      wr_en_n = 1'b1; wr_en_p = 1'b0;
      settle(4);
      chk("R9 write blocked in load cycle", empty_n, 1'b0);
      do_load(8'd10);
      for (int i = 0; i < 3; i++) push(1);
      settle(4);
      chk("R9 aempty_n level 3 offset 3", aempty_n, 1'b0);
      push(0);
      settle(4);
      chk("R9 aempty_n level 4 offset 3", aempty_n, 1'b1);
      for (int i = 0; i < 241; i++) push(i[2]);
      settle(4);
      chk("R9 afull_n level 245 offset 10", afull_n, 1'b1);
      push(1);
      chk("R9 afull_n level 246 offset 10", afull_n, 1'b0);
      drain("R9 drain");
      do_load(8'd0);
      push(1);
      settle(4);
      chk("R9 third load targets empty offset", aempty_n, 1'b1);
      drain("R9 drain after third load");
   endtask

   task automatic t_oe();
      push(0);
      settle(4);
      pop("R10 read zero");
      out_en_n = 1'b1;
      #1;
      chk("R10 dout released when disabled", dout, 1'b1);
      out_en_n = 1'b0;
      #1;
      chk("R10 dout driven when enabled", dout, 1'b0);
      @(negedge clk);
   endtask

   task automatic t_reset_mid();
      push(1);
      settle(4);
      pop("R11 setup read");
      for (int i = 0; i < 5; i++) push(0);
      do_load(8'd2);
      do_load(8'd2);
      do_reset();
      chk("R11 mid empty_n", empty_n, 1'b0);
      chk("R11 mid aempty_n", aempty_n, 1'b0);
      chk("R11 mid full_n", full_n, 1'b1);
      chk("R11 mid afull_n", afull_n, 1'b1);
      chk("R11 mid dout cleared", dout, 1'b0);
      for (int i = 0; i < 7; i++) push(1);
      settle(4);
      chk("R11 empty offset back to 7 (level 7)", aempty_n, 1'b0);
      push(1);
      settle(4);
      chk("R11 empty offset back to 7 (level 8)", aempty_n, 1'b1);
      drain("R11 drain after reset");
   endtask

   initial begin
      settle(3);
      rst_n = 1'b1;
      settle(1);
      t_reset();
      t_order();
      t_gate();
      t_empty_read();
      t_simul();
      t_aempty();
      t_full();
      t_program();
      t_oe();
      t_reset_mid();
      settle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule